// File: doc/BRIEF.md
# Rate-1/3 Parallel Concatenated Convolutional Encoder

This block turns a block of information bits into a rate-1/3 turbo code stream. Two identical 8-state recursive systematic constituent encoders run in lock step. The first one sees the information bits in natural order and produces the first parity bit. The second one sees the same bits in interleaved order and produces the second parity bit. The interleaved stream is computed elsewhere and arrives beside the natural one on the same input beat. Each data beat carries one natural bit and one interleaved bit, and yields the systematic bit, parity 1 and parity 2.

The block length is set by the markers. The first beat of a block carries the start marker and the last information beat carries the end marker, so any length from 40 to 6144 is accepted without setting up anything. After the end-marked beat, the input side closes. Both encoders then spend three steps feeding their own feedback value back in, which flushes their registers to zero. Each of these tail steps puts out four bits, so a block gets twelve tail bits in total. The next block then starts from the all-zero state.

Both sides use valid/ready. An input beat transfers on a rising edge where `in_valid` and `in_ready` are both high. An output beat transfers where `out_valid` and `out_ready` are both high. While the consumer holds `out_ready` low, the beat on the output stays unchanged and `in_ready` stays low. No input is taken while the tail is being generated.

Top module: `pccc_encoder`

## Requirements
- R1: While reset is applied and after it is released, `out_valid` is 0. With no beat pending, `in_ready` is 1.
- R2: On a data beat, `out_x` equals the natural input bit. `out_y1` is the parity of a recursive encoder that starts at zero, with feedback polynomial 1+D^2+D^3 and parity polynomial 1+D+D^3, driven by the natural bits in order.
- R3: On a data beat, `out_y2` is the parity of a second encoder of the same code, driven by the interleaved bits in order.
- R4: After the beat carrying `in_eob`, exactly three tail beats follow, with `out_tail`=1. `in_ready` is 0 until the third tail beat has been loaded into the output stage.
- R5: On tail beats, each encoder takes its feedback value as its input. `out_x`/`out_y1` carry the tail systematic and parity bits of encoder 1, and `out_x2`/`out_y2` carry those of encoder 2. After the third tail beat, both encoders are in state zero.
- R6: `out_sob` is 1 only on the first data beat of a block. `out_eob` is 1 only on the third tail beat.
- R7: While `out_valid`=1 and `out_ready`=0, every output holds its value and `out_valid` stays 1.
- R8: Each block after the first is encoded from the all-zero state, even when it is streamed back to back with the previous block.
- R9: `out_x2` is 0 on every data beat.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Input beat offered |
| in_ready | output | 1 | Encoder can take an input beat |
| in_nat | input | 1 | Information bit, natural order |
| in_ilv | input | 1 | Information bit, interleaved order |
| in_sob | input | 1 | First beat of a block |
| in_eob | input | 1 | Last information beat of a block |
| out_valid | output | 1 | Output beat present |
| out_ready | input | 1 | Consumer takes the output beat |
| out_x | output | 1 | Systematic bit (tail: encoder 1 tail systematic) |
| out_y1 | output | 1 | Parity of encoder 1 |
| out_x2 | output | 1 | Encoder 2 tail systematic bit, 0 on data beats |
| out_y2 | output | 1 | Parity of encoder 2 |
| out_tail | output | 1 | Beat belongs to the tail |
| out_sob | output | 1 | First beat of a block |
| out_eob | output | 1 | Last tail beat of a block |

## Verification
Each output beat is due one clock after the input beat that causes it, because a single register stage lies between the two sides. The three tail beats follow one per cycle in which the output slot is free. The bench records the handshake outcome shortly after each falling edge and settles the transfer at the next falling edge. Each transferred output beat is matched in order against a bit-level model computed in the bench. Blocks are streamed back to back while `out_ready` and `in_valid` are toggled in irregular patterns. A stalled beat is compared again one cycle later to confirm that it held.

// File: rtl/pccc_pkg.sv
package pccc_pkg;
  localparam int unsigned RSC_MEM = 3;
  // bit i is the coefficient of D^i
  localparam logic [RSC_MEM:0] FB_POLY_DEF = 4'b1101; // 1+D^2+D^3
  localparam logic [RSC_MEM:0] FF_POLY_DEF = 4'b1011; // 1+D+D^3

  typedef enum logic {PH_DATA = 1'b0, PH_TAIL = 1'b1} phase_t;

  typedef struct packed {
    logic x;
    logic y1;
    logic x2;
    logic y2;
    logic tail;
    logic sob;
    logic eob;
  } beat_t;
endpackage

// File: rtl/rsc_encoder.sv
module rsc_encoder #(
  parameter int unsigned     MEM     = 3,
  parameter logic [MEM:0]    FB_POLY = 4'b1101,
  parameter logic [MEM:0]    FF_POLY = 4'b1011
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           step,
  input  logic           term,
  input  logic           u_in,
  output logic           sys_out,
  output logic           par_out,
  output logic [MEM-1:0] state_out
);
  // dly[i] holds the value delayed by i+1 steps
  logic [MEM-1:0] dly;
  logic           fb;
  logic           a_in;
  logic           par;

  always_comb begin
    fb = 1'b0;
    for (int i = 1; i <= int'(MEM); i++) begin
      fb = fb ^ (FB_POLY[i] & dly[i-1]);
    end
  end

  // in termination the input equals the feedback, so the register input is zero
  assign a_in    = term ? 1'b0 : (u_in ^ fb);
  assign sys_out = term ? fb : u_in;

  always_comb begin
    par = FF_POLY[0] & a_in;
    for (int i = 1; i <= int'(MEM); i++) begin
      par = par ^ (FF_POLY[i] & dly[i-1]);
    end
  end
  assign par_out = par;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dly <= '0;
    end else if (step) begin
      dly <= {dly[MEM-2:0], a_in};
    end
  end

  assign state_out = dly;

  // R5: a tail step never shifts a one into the register
  p_tail_shift_zero_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (step && term) |=> (dly[0] == 1'b0));
endmodule

// File: rtl/pccc_ctrl.sv
module pccc_ctrl
  import pccc_pkg::*;
#(
  parameter int unsigned MEM = 3
) (
  input  logic clk,
  input  logic rst_n,
  input  logic in_valid,
  input  logic in_eob,
  input  logic slot_free,
  output logic in_ready,
  output logic load,
  output logic term,
  output logic last_tail,
  output logic accept
);
  localparam int unsigned TW = (MEM > 1) ? $clog2(MEM) : 1;
  localparam logic [TW-1:0] TLAST = TW'(MEM - 1);

  phase_t        phase;
  logic [TW-1:0] tcnt;
  logic          tail_load;

  assign in_ready  = (phase == PH_DATA) && slot_free;
  assign accept    = in_valid && in_ready;
  assign tail_load = (phase == PH_TAIL) && slot_free;
  assign load      = accept || tail_load;
  assign term      = (phase == PH_TAIL);
  assign last_tail = tail_load && (tcnt == TLAST);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase <= PH_DATA;
      tcnt  <= '0;
    end else if (accept && in_eob) begin
      phase <= PH_TAIL;
      tcnt  <= '0;
    end else if (tail_load) begin
      if (tcnt == TLAST) begin
        phase <= PH_DATA;
        tcnt  <= '0;
      end else begin
        tcnt <= tcnt + 1'b1;
      end
    end
  end

  p_tcnt_range_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (phase == PH_TAIL) |-> (tcnt <= TLAST));
  p_eob_enters_tail_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && in_eob) |=> (!in_ready && term));
endmodule

// File: rtl/pccc_outstage.sv
module pccc_outstage
  import pccc_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  logic  load,
  input  beat_t beat_in,
  input  logic  out_ready,
  output logic  out_valid,
  output beat_t beat_out,
  output logic  slot_free
);
  assign slot_free = !out_valid || out_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      beat_out  <= '0;
    end else if (load) begin
      out_valid <= 1'b1;
      beat_out  <= beat_in;
    end else if (out_ready) begin
      out_valid <= 1'b0;
    end
  end

  p_stall_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(beat_out)));
  p_reset_idle_r1: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> !out_valid);
endmodule

// File: rtl/pccc_encoder.sv
module pccc_encoder
  import pccc_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic in_valid,
  output logic in_ready,
  input  logic in_nat,
  input  logic in_ilv,
  input  logic in_sob,
  input  logic in_eob,
  output logic out_valid,
  input  logic out_ready,
  output logic out_x,
  output logic out_y1,
  output logic out_x2,
  output logic out_y2,
  output logic out_tail,
  output logic out_sob,
  output logic out_eob
);
  localparam int unsigned NENC = 2;

  logic load, term, last_tail, accept, slot_free;
  logic [NENC-1:0] u_vec, sys_vec, par_vec;
  logic [RSC_MEM-1:0] st [NENC];
  beat_t nxt, cur;

  pccc_ctrl #(.MEM(RSC_MEM)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_eob(in_eob),
    .slot_free(slot_free), .in_ready(in_ready), .load(load), .term(term),
    .last_tail(last_tail), .accept(accept)
  );

  assign u_vec = {in_ilv, in_nat};

  for (genvar g = 0; g < NENC; g++) begin : g_enc
    rsc_encoder #(.MEM(RSC_MEM), .FB_POLY(FB_POLY_DEF), .FF_POLY(FF_POLY_DEF)) u_rsc (
      .clk(clk), .rst_n(rst_n), .step(load), .term(term), .u_in(u_vec[g]),
      .sys_out(sys_vec[g]), .par_out(par_vec[g]), .state_out(st[g])
    );
  end

  always_comb begin
    nxt.x    = sys_vec[0];
    nxt.y1   = par_vec[0];
    nxt.x2   = term ? sys_vec[1] : 1'b0;
    nxt.y2   = par_vec[1];
    nxt.tail = term;
    nxt.sob  = accept && in_sob;
    nxt.eob  = last_tail;
  end

  pccc_outstage u_out (
    .clk(clk), .rst_n(rst_n), .load(load), .beat_in(nxt),
    .out_ready(out_ready), .out_valid(out_valid), .beat_out(cur), .slot_free(slot_free)
  );

  assign out_x    = cur.x;
  assign out_y1   = cur.y1;
  assign out_x2   = cur.x2;
  assign out_y2   = cur.y2;
  assign out_tail = cur.tail;
  assign out_sob  = cur.sob;
  assign out_eob  = cur.eob;

  p_zero_after_tail_r5: assert property (@(posedge clk) disable iff (!rst_n)
    last_tail |=> ((st[0] == '0) && (st[1] == '0)));
  p_x2_data_zero_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_tail) |-> !out_x2);
  p_markers_apart_r6: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> !(out_sob && (out_eob || out_tail)));
endmodule

// File: tb/pccc_encoder_test.sv
module pccc_encoder_test;
  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic rst_n, in_valid, in_ready, in_nat, in_ilv, in_sob, in_eob;
  logic out_valid, out_ready, out_x, out_y1, out_x2, out_y2, out_tail, out_sob, out_eob;

  pccc_encoder uut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_nat(in_nat), .in_ilv(in_ilv), .in_sob(in_sob), .in_eob(in_eob),
    .out_valid(out_valid), .out_ready(out_ready), .out_x(out_x), .out_y1(out_y1),
    .out_x2(out_x2), .out_y2(out_y2), .out_tail(out_tail), .out_sob(out_sob),
    .out_eob(out_eob)
  );

  int n_chk = 0, n_bad = 0;
  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // input stream and expected output stream; beat bits {x,y1,x2,y2,tail,sob,eob}
  bit su [512], sv [512], ssob [512], seob [512];
  logic [6:0] eb [512];
  int eblk [512];
  int n_in = 0, n_out = 0, n_blk = 0;

  task automatic build_block(input int len, input int pat);
    bit ub [64];
    bit a1, a2, a3, b1, b2, b3, f, a, v;
    int lf = 5 + pat;
    a1 = 0; a2 = 0; a3 = 0; b1 = 0; b2 = 0; b3 = 0;
    for (int i = 0; i < len; i++) begin
      case (pat)
        0: ub[i] = 1'b0;
        1: ub[i] = 1'b1;
        2: ub[i] = bit'(i % 2);
        default: begin
          lf = (lf * 1103 + 12345) % 65536;
          ub[i] = bit'((lf >> 7) & 1);
        end
      endcase
    end
    for (int i = 0; i < len; i++) begin
      v = ub[(3 * i + 10 * i * i) % len];
      su[n_in] = ub[i]; sv[n_in] = v;
      ssob[n_in] = (i == 0); seob[n_in] = (i == len - 1);
      n_in++;
      f = a2 ^ a3; a = ub[i] ^ f;
      eb[n_out][6] = ub[i]; eb[n_out][5] = a ^ a1 ^ a3;
      a3 = a2; a2 = a1; a1 = a;
      f = b2 ^ b3; a = v ^ f;
      eb[n_out][4] = 1'b0; eb[n_out][3] = a ^ b1 ^ b3;
      b3 = b2; b2 = b1; b1 = a;
      eb[n_out][2:0] = {1'b0, (i == 0), 1'b0};
      eblk[n_out] = n_blk;
      n_out++;
    end
    for (int t = 0; t < 3; t++) begin
      eb[n_out][6] = a2 ^ a3; eb[n_out][5] = a1 ^ a3;
      a3 = a2; a2 = a1; a1 = 1'b0;
      eb[n_out][4] = b2 ^ b3; eb[n_out][3] = b1 ^ b3;
      b3 = b2; b2 = b1; b1 = 1'b0;
      eb[n_out][2:0] = {1'b1, 1'b0, (t == 2)};
      eblk[n_out] = n_blk;
      n_out++;
    end
    n_blk++;
  endtask

  function automatic logic [6:0] cur_beat();
    return {out_x, out_y1, out_x2, out_y2, out_tail, out_sob, out_eob};
  endfunction

  initial begin
    int idx = 0, k = 0, cyc = 0, first_k = 0;
    bit wa = 0, wc = 0, stalled = 0;
    logic [6:0] cap = '0, scap = '0;
    rst_n = 1'b0; in_valid = 1'b0; in_nat = 1'b0; in_ilv = 1'b0;
    in_sob = 1'b0; in_eob = 1'b0; out_ready = 1'b1;
    build_block(40, 0);
    build_block(40, 1);
    build_block(41, 2);
    build_block(64, 3);
    build_block(47, 4);
    build_block(40, 3);
    repeat (3) @(negedge clk);
    chk(!out_valid, "R1 out_valid in reset", int'(out_valid), 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(!out_valid, "R1 out_valid after reset", int'(out_valid), 0);
    chk(in_ready, "R1 in_ready after reset", int'(in_ready), 1);
    while (k < n_out && cyc < 20000) begin
      @(negedge clk);
      cyc++;
      if (stalled) begin
        chk(out_valid && cur_beat() == scap, "R7 stalled beat held",
            int'(cur_beat()), int'(scap));
      end
      if (wc) begin
        if (eb[k][2]) begin
          chk(cap[6:3] == eb[k][6:3], "R5 tail bits", int'(cap[6:3]), int'(eb[k][6:3]));
        end else begin
          chk(cap[6:5] == eb[k][6:5], "R2 x/y1", int'(cap[6:5]), int'(eb[k][6:5]));
          chk(cap[3] == eb[k][3], "R3 y2", int'(cap[3]), int'(eb[k][3]));
          chk(cap[4] == 1'b0, "R9 x2 on data", int'(cap[4]), 0);
          if (eblk[k] > 0 && k - first_k < 4) begin
            // R8: later block starts from zero state
            chk(cap[6:3] == eb[k][6:3], "R8 block start state", int'(cap[6:3]), int'(eb[k][6:3]));
          end
        end
        if (eb[k][1]) first_k = k;
        chk(cap[2] == eb[k][2], "R4 tail beat position", int'(cap[2]), int'(eb[k][2]));
        chk(cap[1:0] == eb[k][1:0], "R6 sob/eob", int'(cap[1:0]), int'(eb[k][1:0]));
        k++;
      end
      if (wa) idx++;
      out_ready = (cyc < 120) ? 1'b1 : ((cyc % 5 != 2) && (cyc % 7 != 0));
      in_valid  = (idx < n_in) && !(cyc >= 250 && cyc % 6 == 3);
      in_nat    = (idx < n_in) ? su[idx] : 1'b0;
      in_ilv    = (idx < n_in) ? sv[idx] : 1'b0;
      in_sob    = (idx < n_in) ? ssob[idx] : 1'b0;
      in_eob    = (idx < n_in) ? seob[idx] : 1'b0;
      #1;
      wa = in_valid && in_ready;
      wc = out_valid && out_ready;
      cap = cur_beat();
      stalled = out_valid && !out_ready;
      scap = cap;
    end
    if (cyc >= 20000) chk(1'b0, "watchdog expired", k, n_out);
    chk(idx == n_in, "R4 all input beats taken", idx, n_in);
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule